// File: doc/BRIEF.md
# Hardware Stack Pointer Unit

This block owns the data-memory stack pointer used for subroutine calls, returns, exception entry and exception return. A controller raises a push or pop request. For a single word the request moves one data word. For a program-counter frame it moves a 24-bit program counter split over two words, and it can also carry the low status byte. The block drives a word address, write data, write enable and read enable toward a synchronous data RAM. It hands popped words, rebuilt program counters and restored status bytes back to the controller.

The stack grows toward higher addresses, and the pointer always holds the address of the first free word. A push stores at the pointer and then adds 2. A pop first subtracts 2 and then reads. A limit register bounds the stack: a push that would move the pointer past the limit is refused and flagged with a one-cycle error pulse. Software can overwrite both the pointer and the limit. Bit 0 of each is always held at zero.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0200, the limit reads 0xFFFE, `ready` is 1, and `stk_err`, `mem_we`, `mem_re`, `pop_valid` and `pc_valid` are 0.
- R2: Bit 0 of `sp_out` and of `lim_out` is always 0; a software write of an odd value stores that value with bit 0 cleared, visible the cycle after the write.
- R3: An accepted single-word push (`req_frame`=0) gives, in the next cycle, `mem_we`=1, `mem_addr` equal to the old pointer, `mem_wdata` equal to `push_wdata`, and a pointer equal to the old pointer plus 2.
- R4: An accepted single-word pop gives, in the next cycle, `mem_re`=1, with `mem_addr` and the pointer both equal to the old pointer minus 2. The word read appears on `pop_data` with `pop_valid`=1 for exactly one cycle, three cycles after acceptance. The RAM returns data one cycle after `mem_re`.
- R5: An accepted frame push with `req_exc`=0 writes `pc_in[15:0]` at the old pointer in the next cycle. In the cycle after that it writes {8'h00, `pc_in[23:16]`} at the old pointer plus 2, and the pointer ends at the old value plus 4. `ready` is 0 between the two writes.
- R6: A frame push with `req_exc`=1 behaves as R5, except that the upper byte of the second word is `sr_lo_in`.
- R7: An accepted frame pop reads the old pointer minus 2 in the next cycle, then reads the old pointer minus 4 three cycles after acceptance. Five cycles after acceptance it presents `pc_out` = {first word[7:0], second word} with `pc_valid`=1 for one cycle, and the pointer ends at the old value minus 4.
- R8: In the `pc_valid` cycle, `sr_valid` equals the `req_exc` value of the frame pop, and when it is 1, `sr_out` is the upper byte of the first word read.
- R9: A single push for which old pointer + 2 exceeds the limit, or a frame push for which old pointer + 4 exceeds the limit, gives a one-cycle `stk_err` pulse in the next cycle, with no memory write and an unchanged pointer. The sum is taken without wrap-around.
- R10: `req_push` and `req_pop` high together while `ready` gives a `stk_err` pulse in the next cycle, with no memory access and an unchanged pointer.
- R11: A software write (`sw_sp_we` or `sw_lim_we`) while `ready` takes priority. Any push or pop request in that cycle is dropped without an error and without a memory access.
- R12: While `ready` is 0, requests and software writes have no effect on memory, pointer or limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_push | input | 1 | Push request |
| req_pop | input | 1 | Pop request |
| req_frame | input | 1 | Request moves a program-counter frame instead of one word |
| req_exc | input | 1 | Frame belongs to exception entry or exit (status byte carried) |
| push_wdata | input | 16 | Word to push for single-word pushes |
| pc_in | input | 24 | Program counter to save |
| sr_lo_in | input | 8 | Low status byte saved on exception entry |
| sw_sp_we | input | 1 | Software write of the pointer |
| sw_lim_we | input | 1 | Software write of the limit |
| sw_wdata | input | 16 | Software write value |
| ready | output | 1 | Block idle and accepting requests |
| sp_out | output | 16 | Current stack pointer |
| lim_out | output | 16 | Current limit |
| stk_err | output | 1 | One-cycle error pulse |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_addr | output | 16 | RAM byte address (always even) |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid one cycle after `mem_re` |
| pop_valid | output | 1 | Popped word valid |
| pop_data | output | 16 | Popped word |
| pc_valid | output | 1 | Restored program counter valid |
| pc_out | output | 24 | Restored program counter |
| sr_valid | output | 1 | Restored status byte valid |
| sr_out | output | 8 | Restored status byte |

## Verification
The assertions assume that the controller raises requests only while `ready` is high, or that the block ignores requests raised while it is low. They also assume the RAM returns read data exactly one cycle after `mem_re`. The bench attaches a one-cycle RAM model and applies each request for a single cycle while `ready` is high. The one exception is a deliberate probe of R12, where a pop and a software write are raised in the middle of a frame push. Limit tests place the pointer and limit at every even distance up to 6, so each push and frame push is tried on both sides of the overflow boundary.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_HI = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_RD_TAKE = 2'd3
    } stk_state_e;

    localparam int unsigned WORD_BYTES = 2;
endpackage

// File: rtl/stk_ptr_math.sv
module stk_ptr_math #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] lim,
    output logic [AW-1:0] sp_up,
    output logic [AW-1:0] sp_dn,
    output logic          ovf_word,
    output logic          ovf_frame
);
    localparam logic [AW:0] STEP1 = (AW+1)'(stk_pkg::WORD_BYTES);
    localparam logic [AW:0] STEP2 = (AW+1)'(2 * stk_pkg::WORD_BYTES);

    logic [AW:0] sum1;
    logic [AW:0] sum2;

    always_comb begin
        sum1      = {1'b0, sp} + STEP1;
        sum2      = {1'b0, sp} + STEP2;
        sp_up     = sum1[AW-1:0];
        sp_dn     = sp - AW'(stk_pkg::WORD_BYTES);
        // compare without wrap so a push past the top of memory also fails
        ovf_word  = sum1 > {1'b0, lim};
        ovf_frame = sum2 > {1'b0, lim};
    end
endmodule

// File: rtl/stk_frame_fmt.sv
module stk_frame_fmt #(
    parameter int unsigned DW  = 16,
    parameter int unsigned PCW = 24,
    parameter int unsigned SRW = 8
) (
    input  logic [PCW-DW-1:0] pc_hi_in,
    input  logic [SRW-1:0]    sr_in,
    input  logic              is_exc,
    output logic [DW-1:0]     hi_word,
    input  logic [DW-1:0]     rd_word,
    output logic [PCW-DW-1:0] pc_hi_out,
    output logic [SRW-1:0]    sr_out
);
    localparam int unsigned PCHI = PCW - DW;
    localparam int unsigned PAD  = DW - PCHI - SRW;

    logic [SRW-1:0] tag;
    assign tag = is_exc ? sr_in : '0;

    generate
        if (PAD > 0) begin : g_pad
            assign hi_word = {{PAD{1'b0}}, tag, pc_hi_in};
        end else begin : g_nopad
            assign hi_word = {tag, pc_hi_in};
        end
    endgenerate

    assign pc_hi_out = rd_word[PCHI-1:0];
    assign sr_out    = rd_word[PCHI+SRW-1:PCHI];
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
    parameter int unsigned   AW        = 16,
    parameter int unsigned   DW        = 16,
    parameter int unsigned   PCW       = 24,
    parameter int unsigned   SRW       = 8,
    parameter logic [AW-1:0] RESET_SP  = 16'h0200,
    parameter logic [AW-1:0] RESET_LIM = 16'hFFFE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_push,
    input  logic           req_pop,
    input  logic           req_frame,
    input  logic           req_exc,
    input  logic [DW-1:0]  push_wdata,
    input  logic [PCW-1:0] pc_in,
    input  logic [SRW-1:0] sr_lo_in,
    input  logic           sw_sp_we,
    input  logic           sw_lim_we,
    input  logic [AW-1:0]  sw_wdata,
    output logic           ready,
    output logic [AW-1:0]  sp_out,
    output logic [AW-1:0]  lim_out,
    output logic           stk_err,
    output logic           mem_we,
    output logic           mem_re,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           pop_valid,
    output logic [DW-1:0]  pop_data,
    output logic           pc_valid,
    output logic [PCW-1:0] pc_out,
    output logic           sr_valid,
    output logic [SRW-1:0] sr_out
);
    import stk_pkg::*;

    localparam int unsigned   PCHI     = PCW - DW;
    localparam logic [AW-1:0] EVEN_MSK = ~AW'(1);

    typedef struct packed {
        stk_state_e     st;
        logic [AW-1:0]  sp;
        logic [AW-1:0]  lim;
        logic [DW-1:0]  hold;
        logic           rd_hi;
        logic           rd_frame;
        logic           rd_exc;
        logic           err;
        logic           we;
        logic           re;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic           pop_v;
        logic [DW-1:0]  pop_d;
        logic           pc_v;
        logic [PCW-1:0] pc;
        logic           sr_v;
        logic [SRW-1:0] sr;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0]   sp_up, sp_dn;
    logic            ovf_word, ovf_frame;
    logic [DW-1:0]   hi_word;
    logic [PCHI-1:0] hold_pc_hi;
    logic [SRW-1:0]  hold_sr;

    stk_ptr_math #(.AW(AW)) u_math (
        .sp        (r_q.sp),
        .lim       (r_q.lim),
        .sp_up     (sp_up),
        .sp_dn     (sp_dn),
        .ovf_word  (ovf_word),
        .ovf_frame (ovf_frame)
    );

    stk_frame_fmt #(.DW(DW), .PCW(PCW), .SRW(SRW)) u_fmt (
        .pc_hi_in  (pc_in[PCW-1:DW]),
        .sr_in     (sr_lo_in),
        .is_exc    (req_exc),
        .hi_word   (hi_word),
        .rd_word   (r_q.hold),
        .pc_hi_out (hold_pc_hi),
        .sr_out    (hold_sr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        r_d.we    = 1'b0;
        r_d.re    = 1'b0;
        r_d.pop_v = 1'b0;
        r_d.pc_v  = 1'b0;
        r_d.sr_v  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sw_sp_we || sw_lim_we) begin
                    if (sw_sp_we)  r_d.sp  = sw_wdata & EVEN_MSK;
                    if (sw_lim_we) r_d.lim = sw_wdata & EVEN_MSK;
                end else if (req_push && req_pop) begin
                    r_d.err = 1'b1;
                end else if (req_push) begin
                    if (req_frame ? ovf_frame : ovf_word) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.we    = 1'b1;
                        r_d.addr  = r_q.sp;
                        r_d.wdata = req_frame ? pc_in[DW-1:0] : push_wdata;
                        r_d.sp    = sp_up;
                        if (req_frame) begin
                            r_d.hold = hi_word;
                            r_d.st   = ST_PUSH_HI;
                        end
                    end
                end else if (req_pop) begin
                    r_d.re       = 1'b1;
                    r_d.addr     = sp_dn;
                    r_d.sp       = sp_dn;
                    r_d.rd_frame = req_frame;
                    r_d.rd_hi    = req_frame;
                    r_d.rd_exc   = req_exc;
                    r_d.st       = ST_RD_WAIT;
                end
            end
            ST_PUSH_HI: begin
                r_d.we    = 1'b1;
                r_d.addr  = r_q.sp;
                r_d.wdata = r_q.hold;
                r_d.sp    = sp_up;
                r_d.st    = ST_IDLE;
            end
            ST_RD_WAIT: begin
                r_d.st = ST_RD_TAKE;
            end
            ST_RD_TAKE: begin
                if (r_q.rd_hi) begin
                    r_d.hold  = mem_rdata;
                    r_d.rd_hi = 1'b0;
                    r_d.re    = 1'b1;
                    r_d.addr  = sp_dn;
                    r_d.sp    = sp_dn;
                    r_d.st    = ST_RD_WAIT;
                end else if (r_q.rd_frame) begin
                    r_d.pc   = {hold_pc_hi, mem_rdata};
                    r_d.pc_v = 1'b1;
                    r_d.sr_v = r_q.rd_exc;
                    if (r_q.rd_exc) r_d.sr = hold_sr;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.pop_d = mem_rdata;
                    r_d.pop_v = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.sp  <= RESET_SP & EVEN_MSK;
            r_q.lim <= RESET_LIM & EVEN_MSK;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign sp_out    = r_q.sp;
    assign lim_out   = r_q.lim;
    assign stk_err   = r_q.err;
    assign mem_we    = r_q.we;
    assign mem_re    = r_q.re;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign pop_valid = r_q.pop_v;
    assign pop_data  = r_q.pop_d;
    assign pc_valid  = r_q.pc_v;
    assign pc_out    = r_q.pc;
    assign sr_valid  = r_q.sr_v;
    assign sr_out    = r_q.sr;
endmodule

// File: rtl/stk_ptr_unit_chk.sv
module stk_ptr_unit_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_push,
    input logic          req_pop,
    input logic          req_frame,
    input logic          sw_sp_we,
    input logic          sw_lim_we,
    input logic          ready,
    input logic [AW-1:0] sp_out,
    input logic [AW-1:0] lim_out,
    input logic          stk_err,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          pc_valid,
    input logic          sr_valid
);
    logic sw_any;
    assign sw_any = sw_sp_we || sw_lim_we;

    // R2
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_out[0] && !lim_out[0]);

    // R3
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && req_push && !req_pop && !req_frame && !sw_any &&
        (({1'b0, sp_out} + (AW+1)'(2)) <= {1'b0, lim_out})
        |=> mem_we && mem_addr == $past(sp_out) && sp_out == $past(sp_out) + AW'(2));

    // R4
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && req_pop && !req_push && !sw_any
        |=> mem_re && mem_addr == $past(sp_out) - AW'(2) && sp_out == $past(sp_out) - AW'(2));

    // R9
    err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |-> !mem_we && !mem_re);

    // R10
    both_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && req_push && req_pop && !sw_any |=> stk_err && $stable(sp_out));

    // R8
    sr_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_valid |-> pc_valid);

    // R12
    busy_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(lim_out));
endmodule

bind stk_ptr_unit stk_ptr_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/stk_ptr_unit_bench.sv
module stk_ptr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_push = 0, req_pop = 0, req_frame = 0, req_exc = 0;
    logic [15:0] push_wdata = '0;
    logic [23:0] pc_in = '0;
    logic [7:0]  sr_lo_in = '0;
    logic        sw_sp_we = 0, sw_lim_we = 0;
    logic [15:0] sw_wdata = '0;
    logic        ready, stk_err, mem_we, mem_re, pop_valid, pc_valid, sr_valid;
    logic [15:0] sp_out, lim_out, mem_addr, mem_wdata, mem_rdata, pop_data;
    logic [23:0] pc_out;
    logic [7:0]  sr_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [15:0] exp_sp;
    logic [15:0] model [0:63];
    int          depth = 0;
    logic [15:0] ram [0:1023];

    always #2 clk = ~clk;

    stk_ptr_unit u_stk_ptr_unit (.*);

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[10:1]] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr[10:1]];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sw_set(input logic [15:0] spv, input logic [15:0] limv);
        sw_sp_we = 1; sw_wdata = spv;
        step();
        sw_sp_we = 0; sw_lim_we = 1; sw_wdata = limv;
        step();
        sw_lim_we = 0;
        exp_sp = spv & 16'hFFFE;
    endtask

    task automatic push_w(input logic [15:0] d);
        req_push = 1; req_frame = 0; push_wdata = d;
        step();
        req_push = 0;
        chk("R3 we", mem_we, 1);
        chk("R3 addr", mem_addr, exp_sp);
        chk("R3 wdata", mem_wdata, d);
        exp_sp = exp_sp + 16'd2;
        chk("R3 sp", sp_out, exp_sp);
        model[depth] = d; depth++;
    endtask

    task automatic pop_w();
        logic [15:0] e;
        depth--; e = model[depth];
        req_pop = 1; req_frame = 0;
        step();
        req_pop = 0;
        exp_sp = exp_sp - 16'd2;
        chk("R4 re", mem_re, 1);
        chk("R4 addr", mem_addr, exp_sp);
        chk("R4 sp", sp_out, exp_sp);
        @(posedge clk); step();
        chk("R4 valid", pop_valid, 1);
        chk("R4 data", pop_data, e);
        step();
        chk("R4 one cycle", pop_valid, 0);
    endtask

    task automatic push_f(input logic [23:0] pc, input logic [7:0] sr, input logic exc);
        req_push = 1; req_frame = 1; req_exc = exc; pc_in = pc; sr_lo_in = sr;
        step();
        req_push = 0; req_frame = 0;
        chk("R5 we lo", mem_we, 1);
        chk("R5 addr lo", mem_addr, exp_sp);
        chk("R5 data lo", mem_wdata, pc[15:0]);
        chk("R5 busy", ready, 0);
        step();
        chk("R5 we hi", mem_we, 1);
        chk("R5 addr hi", mem_addr, exp_sp + 16'd2);
        chk(exc ? "R6 data hi" : "R5 data hi", mem_wdata, {exc ? sr : 8'h00, pc[23:16]});
        exp_sp = exp_sp + 16'd4;
        chk("R5 sp", sp_out, exp_sp);
    endtask

    task automatic pop_f(input logic [23:0] pc, input logic [7:0] sr, input logic exc);
        req_pop = 1; req_frame = 1; req_exc = exc;
        step();
        req_pop = 0; req_frame = 0;
        chk("R7 re hi", mem_re, 1);
        chk("R7 addr hi", mem_addr, exp_sp - 16'd2);
        @(posedge clk); step();
        chk("R7 re lo", mem_re, 1);
        chk("R7 addr lo", mem_addr, exp_sp - 16'd4);
        @(posedge clk); step();
        exp_sp = exp_sp - 16'd4;
        chk("R7 valid", pc_valid, 1);
        chk("R7 pc", pc_out, pc);
        chk("R7 sp", sp_out, exp_sp);
        chk("R8 sr_valid", sr_valid, exc);
        if (exc) chk("R8 sr", sr_out, sr);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        exp_sp = 16'h0200;
        chk("R1 sp", sp_out, 16'h0200);
        chk("R1 lim", lim_out, 16'hFFFE);
        chk("R1 ready", ready, 1);
        chk("R1 quiet", {stk_err, mem_we, mem_re, pop_valid, pc_valid}, 0);

        // R2 odd software writes
        sw_set(16'h0123, 16'h7FFF);
        chk("R2 sp", sp_out, 16'h0122);
        chk("R2 lim", lim_out, 16'h7FFE);
        sw_set(16'h0200, 16'hFFFF);
        chk("R2 lim odd", lim_out, 16'hFFFE);

        // R3 R4 LIFO sweep over depths
        for (int n = 1; n <= 6; n++) begin
            for (int i = 0; i < n; i++)
                push_w(16'hA000 ^ 16'(n << 8) ^ 16'(i * 37));
            for (int i = 0; i < n; i++) pop_w();
        end

        // R5 R6 R7 R8 frame sweep
        for (int k = 0; k < 8; k++) begin
            logic [23:0] pc;
            logic [7:0]  sr;
            pc = 24'(k * 24'h2345F1) ^ 24'hC30000;
            sr = 8'h5A ^ 8'(k * 17);
            push_w(16'h1111 * 16'(k));
            push_f(pc, sr, k[0]);
            pop_f(pc, sr, k[0]);
            pop_w();
        end

        // R9 limit boundary sweep
        for (int d = 0; d <= 6; d += 2) begin
            sw_set(16'h0300, 16'(16'h0300 + d));
            req_push = 1; req_frame = 0; push_wdata = 16'hBEEF;
            step();
            req_push = 0;
            chk("R9 word err", stk_err, (d < 2));
            chk("R9 word we", mem_we, (d >= 2));
            chk("R9 word sp", sp_out, (d < 2) ? 16'h0300 : 16'h0302);
            step();
            chk("R9 pulse", stk_err, 0);
            sw_set(16'h0300, 16'(16'h0300 + d));
            req_push = 1; req_frame = 1; req_exc = 0; pc_in = 24'h123456;
            step();
            req_push = 0; req_frame = 0;
            chk("R9 frame err", stk_err, (d < 4));
            chk("R9 frame we", mem_we, (d >= 4));
            step();
            chk("R9 frame sp", sp_out, (d < 4) ? 16'h0300 : 16'h0304);
        end
        sw_set(16'hFFFE, 16'hFFFE);
        req_push = 1; step(); req_push = 0;
        chk("R9 wrap err", stk_err, 1);
        chk("R9 wrap sp", sp_out, 16'hFFFE);

        // R10 push and pop together
        sw_set(16'h0200, 16'hFFFE);
        req_push = 1; req_pop = 1; step(); req_push = 0; req_pop = 0;
        chk("R10 err", stk_err, 1);
        chk("R10 no access", {mem_we, mem_re}, 0);
        chk("R10 sp", sp_out, 16'h0200);

        // R11 software write beats a request
        sw_sp_we = 1; sw_wdata = 16'h0240; req_push = 1;
        step();
        sw_sp_we = 0; req_push = 0;
        chk("R11 sp", sp_out, 16'h0240);
        chk("R11 no write", {mem_we, stk_err}, 0);
        exp_sp = 16'h0240;

        // R12 requests while busy are ignored
        req_push = 1; req_frame = 1; req_exc = 1; pc_in = 24'hABCDEF; sr_lo_in = 8'h3C;
        step();
        req_push = 0; req_frame = 0;
        chk("R12 busy", ready, 0);
        req_pop = 1; sw_sp_we = 1; sw_lim_we = 1; sw_wdata = 16'h0800;
        step();
        req_pop = 0; sw_sp_we = 0; sw_lim_we = 0;
        chk("R12 sp", sp_out, 16'h0244);
        chk("R12 lim", lim_out, 16'hFFFE);
        step();
        chk("R12 no read", {mem_re, mem_we}, 0);
        chk("R12 sp held", sp_out, 16'h0244);
        exp_sp = 16'h0244;
        pop_f(24'hABCDEF, 8'h3C, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule